// File: doc/BRIEF.md
# Serial Mode-Control Port for an Audio Clock Generator

This block is the write-only control port of a multi-output audio clock generator. A host shifts 16-bit words into it over three wires: an active-low select (`ctl_sel_n`), a bit clock (`ctl_sck`) and a data line (`ctl_sdi`). The upper six bits of each word are a header that picks one of two internal registers. The operating-mode register holds six per-output clock enables, a sampling-rate code and a frequency-group code. The setup register holds a single bit that sets the frequency range of output 1.

All three wires pass through two-flop synchronisers into the master-clock domain, and their edges are detected there. A word is applied when the select line rises, provided at least 16 bits were shifted in while the line was low. From the stored state the block derives two signals. The power-down flag is raised when every clock enable is clear. The 2-bit output-1 frequency code is formed from the setup bit and an external range pin. A counted power-on reset holds every field at its default while the supply settles.

Top module: `scp_top`

## Requirements
- R1: Data is sampled on each rising edge of `ctl_sck` while `ctl_sel_n` is low, and enters the shift register MSB first. The word is applied on the rising edge of `ctl_sel_n` if at least 16 bits arrived.
- R2: A word whose bits 15:10 are 011100 writes the operating-mode register. Bits 9:4 go to `clk_en[5:0]`, bits 3:2 go to `rate_code` and bits 1:0 go to `fs_group`.
- R3: A word whose bits 15:10 are 011011 writes the setup register. Bit 4 goes to `range_bit`, and the mode fields are left unchanged.
- R4: A word with any other header, or with fewer than 16 bits before the select line rises, changes no output.
- R5: When more than 16 bits are shifted in, only the last 16 received are decoded.
- R6: After `supply_ok` rises, every field stays at its default for POR_CYCLES (1024) master clocks, and writes during that window are ignored. The defaults are: `fs_group` 00 (48 kHz), `rate_code` 00 (standard), `clk_en` 111111 and `range_bit` 0.
- R7: `power_down` is high exactly when all six enables are 0. Writes are still accepted while it is high, so a write that sets any enable clears it.
- R8: `out1_freq` equals {`range_bit`, `range_pin`}. The codes mean: 00 = 36.864 MHz, 01 = 24.576 MHz, 10 = 18.432 MHz, 11 = 12.288 MHz.
- R9: A mode write whose frequency-group field (00 = 48 kHz, 01 = 44.1 kHz, 10 = 32 kHz) or rate field (00 = standard, 01 = double, 10 = half) holds the reserved code 11 is still stored. It also raises `reserved_err` for exactly one master clock.
- R10: A low level on `supply_ok` returns every field to its default at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| supply_ok | input | 1 | Supply valid; low resets asynchronously |
| ctl_sel_n | input | 1 | Serial select, active low; its rising edge applies the word |
| ctl_sck | input | 1 | Serial bit clock |
| ctl_sdi | input | 1 | Serial data, MSB first |
| range_pin | input | 1 | External output-1 range pin |
| fs_group | output | 2 | Sampling-frequency group code |
| rate_code | output | 2 | Sampling-rate code |
| clk_en | output | 6 | Per-output clock enables |
| range_bit | output | 1 | Stored output-1 setup bit |
| power_down | output | 1 | All enables clear |
| out1_freq | output | 2 | Output-1 frequency code |
| reserved_err | output | 1 | One-cycle pulse on a reserved code in a mode write |

## Verification
The assertions rely on two assumptions about the inputs. First, the serial wires change slowly relative to `mclk`, so every bit-clock level lasts several master cycles. Second, a select rise never falls in the same synchronised cycle as a bit-clock rise. Together these mean that two applied words are always separated by many cycles and that an edge is never missed. The bench holds each bit-clock level for seven master clocks, which gives a 112 ns bit period. It also changes the select line only while the bit clock is low and idle, with a half-period of margin on either side.

// File: rtl/scp_pkg.sv
package scp_pkg;
  localparam int WORD_W = 16;
  localparam int HDR_W  = 6;
  localparam int EN_W   = 6;
  localparam logic [HDR_W-1:0] HDR_MODE  = 6'b011100;
  localparam logic [HDR_W-1:0] HDR_SETUP = 6'b011011;

  typedef struct packed {
    logic [EN_W-1:0] en;
    logic [1:0]      rate;
    logic [1:0]      fs;
    logic            rng;
  } ctl_t;

  localparam ctl_t CTL_DEFAULT = '{en: '1, rate: 2'b00, fs: 2'b00, rng: 1'b0};

  // code 11 is reserved in both 2-bit fields
  function automatic logic code_reserved(input logic [1:0] code);
    return code == 2'b11;
  endfunction

  function automatic logic [1:0] out1_code(input logic rng, input logic pin);
    return {rng, pin};
  endfunction

  function automatic logic [HDR_W-1:0] hdr_of(input logic [WORD_W-1:0] w);
    return w[WORD_W-1 -: HDR_W];
  endfunction
endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/scp_por.sv
module scp_por #(
  parameter int POR_CYCLES = 1024
) (
  input  logic clk,
  input  logic supply_ok,
  output logic por_active
);
  localparam int CNT_W = $clog2(POR_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(POR_CYCLES);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge supply_ok) begin
    if (!supply_ok)       cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign por_active = (cnt != LAST);
endmodule

// File: rtl/scp_shift.sv
module scp_shift
  import scp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              sel_n_s,
  input  logic              sck_s,
  input  logic              sdi_s,
  output logic              commit,
  output logic [WORD_W-1:0] word
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  logic              sel_q, sck_q;
  logic [CNT_W-1:0]  nbits;
  logic [WORD_W-1:0] shreg;
  logic              sel_rise, sck_rise;

  assign sel_rise = sel_n_s & ~sel_q;
  assign sck_rise = sck_s & ~sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b1;
      sck_q <= 1'b0;
      nbits <= '0;
      shreg <= '0;
    end else if (clr) begin
      sel_q <= 1'b1;
      sck_q <= 1'b0;
      nbits <= '0;
      shreg <= '0;
    end else begin
      sel_q <= sel_n_s;
      sck_q <= sck_s;
      if (sel_n_s) begin
        nbits <= '0;
      end else if (sck_rise) begin
        shreg <= {shreg[WORD_W-2:0], sdi_s};
        if (nbits != FULL) nbits <= nbits + 1'b1;
      end
    end
  end

  assign commit = sel_rise & (nbits == FULL) & ~clr;
  assign word   = shreg;
endmodule

// File: rtl/scp_regs.sv
module scp_regs
  import scp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              commit,
  input  logic [WORD_W-1:0] word,
  output ctl_t              ctl,
  output logic              err
);
  logic [HDR_W-1:0] hdr;
  assign hdr = hdr_of(word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= CTL_DEFAULT;
      err <= 1'b0;
    end else if (clr) begin
      ctl <= CTL_DEFAULT;
      err <= 1'b0;
    end else begin
      err <= 1'b0;
      if (commit) begin
        case (hdr)
          HDR_MODE: begin
            ctl.en   <= word[9:4];
            ctl.rate <= word[3:2];
            ctl.fs   <= word[1:0];
            err      <= code_reserved(word[3:2]) | code_reserved(word[1:0]);
          end
          HDR_SETUP: ctl.rng <= word[4];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/scp_top.sv
module scp_top
  import scp_pkg::*;
#(
  parameter int POR_CYCLES = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic            mclk,
  input  logic            supply_ok,
  input  logic            ctl_sel_n,
  input  logic            ctl_sck,
  input  logic            ctl_sdi,
  input  logic            range_pin,
  output logic [1:0]      fs_group,
  output logic [1:0]      rate_code,
  output logic [EN_W-1:0] clk_en,
  output logic            range_bit,
  output logic            power_down,
  output logic [1:0]      out1_freq,
  output logic            reserved_err
);
  logic              por_active;
  logic [2:0]        pins_s;
  logic              commit;
  logic [WORD_W-1:0] word;
  ctl_t              ctl_q;

  scp_por #(.POR_CYCLES(POR_CYCLES)) u_por (
    .clk(mclk), .supply_ok(supply_ok), .por_active(por_active)
  );

  // bit 0 = select (idles high), bit 1 = bit clock, bit 2 = data
  scp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk(mclk), .rst_n(supply_ok),
    .d({ctl_sdi, ctl_sck, ctl_sel_n}), .q(pins_s)
  );

  scp_shift u_shift (
    .clk(mclk), .rst_n(supply_ok), .clr(por_active),
    .sel_n_s(pins_s[0]), .sck_s(pins_s[1]), .sdi_s(pins_s[2]),
    .commit(commit), .word(word)
  );

  scp_regs u_regs (
    .clk(mclk), .rst_n(supply_ok), .clr(por_active),
    .commit(commit), .word(word), .ctl(ctl_q), .err(reserved_err)
  );

  assign fs_group   = ctl_q.fs;
  assign rate_code  = ctl_q.rate;
  assign clk_en     = ctl_q.en;
  assign range_bit  = ctl_q.rng;
  assign power_down = ~|ctl_q.en;
  assign out1_freq  = out1_code(ctl_q.rng, range_pin);
endmodule

// File: rtl/scp_checker.sv
module scp_checker
  import scp_pkg::*;
(
  input logic              mclk,
  input logic              supply_ok,
  input logic              por_active,
  input logic              commit,
  input logic [WORD_W-1:0] word,
  input ctl_t              ctl_q,
  input logic              power_down,
  input logic              reserved_err
);
  AST_POR_HOLDS_DEFAULTS: assert property (@(posedge mclk) disable iff (!supply_ok)
    por_active |-> ctl_q == CTL_DEFAULT); // R6

  AST_MODE_STORE: assert property (@(posedge mclk) disable iff (!supply_ok || por_active)
    (commit && hdr_of(word) == HDR_MODE) |=> ctl_q.en == $past(word[9:4])); // R2

  AST_SETUP_STORE: assert property (@(posedge mclk) disable iff (!supply_ok || por_active)
    (commit && hdr_of(word) == HDR_SETUP) |=> (ctl_q.rng == $past(word[4])) && $stable(ctl_q.en)); // R3

  AST_QUIET_HOLD: assert property (@(posedge mclk) disable iff (!supply_ok || por_active)
    !commit |=> $stable(ctl_q)); // R4

  AST_PD_EXIT_BY_WRITE: assert property (@(posedge mclk) disable iff (!supply_ok || por_active)
    $fell(power_down) |-> $past(commit)); // R7

  AST_ERR_SINGLE: assert property (@(posedge mclk) disable iff (!supply_ok)
    reserved_err |=> !reserved_err); // R9

  AST_ERR_CAUSE: assert property (@(posedge mclk) disable iff (!supply_ok)
    reserved_err |-> $past(commit) && $past(hdr_of(word)) == HDR_MODE); // R9
endmodule

bind scp_top scp_checker u_chk (
  .mclk(mclk), .supply_ok(supply_ok), .por_active(por_active),
  .commit(commit), .word(word), .ctl_q(ctl_q),
  .power_down(power_down), .reserved_err(reserved_err)
);

// File: tb/tb_scp_top.sv
module tb_scp_top;
  logic mclk = 1'b0;
  logic supply_ok = 1'b0;
  logic ctl_sel_n = 1'b1, ctl_sck = 1'b0, ctl_sdi = 1'b0, range_pin = 1'b0;
  logic [1:0] fs_group, rate_code, out1_freq;
  logic [5:0] clk_en;
  logic range_bit, power_down, reserved_err;

  int checks = 0;
  int errors = 0;
  int err_pulses = 0;

  always #4 mclk = ~mclk;

  scp_top dut (
    .mclk(mclk), .supply_ok(supply_ok), .ctl_sel_n(ctl_sel_n), .ctl_sck(ctl_sck),
    .ctl_sdi(ctl_sdi), .range_pin(range_pin), .fs_group(fs_group), .rate_code(rate_code),
    .clk_en(clk_en), .range_bit(range_bit), .power_down(power_down),
    .out1_freq(out1_freq), .reserved_err(reserved_err)
  );

  always @(posedge mclk) if (reserved_err) err_pulses++;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic half_bit();
    repeat (7) @(negedge mclk);
  endtask

  task automatic send(input logic [31:0] v, input int n);
    ctl_sel_n = 1'b0;
    half_bit();
    for (int i = n - 1; i >= 0; i--) begin
      ctl_sdi = v[i];
      half_bit();
      ctl_sck = 1'b1;
      half_bit();
      ctl_sck = 1'b0;
    end
    half_bit();
    ctl_sel_n = 1'b1;
    repeat (8) @(negedge mclk);
  endtask

  task automatic expect_state(input string req, input int en, input int rate,
                              input int fs, input int rng);
    check({req, " clk_en"}, clk_en, en);
    check({req, " rate_code"}, rate_code, rate);
    check({req, " fs_group"}, fs_group, fs);
    check({req, " range_bit"}, range_bit, rng);
    check({req, " power_down"}, power_down, (en == 0) ? 1 : 0);
  endtask

  task automatic t_reset_defaults();
    expect_state("R6 defaults", 6'h3F, 0, 0, 0);
    check("R8 out1 default", out1_freq, 0);
    check("R9 no err at reset", err_pulses, 0);
  endtask

  task automatic t_mode_write();
    int e0 = err_pulses;
    send(32'h72A6, 16);
    expect_state("R1 R2 mode write", 6'h2A, 1, 2, 0);
    check("R9 no err on legal codes", err_pulses - e0, 0);
  endtask

  task automatic t_setup_write();
    send(32'h6C10, 16);
    expect_state("R3 setup write keeps mode", 6'h2A, 1, 2, 1);
    check("R8 range 1 pin 0", out1_freq, 2);
    range_pin = 1'b1; #1;
    check("R8 range 1 pin 1", out1_freq, 3);
    send(32'h6C00, 16);
    check("R8 range 0 pin 1", out1_freq, 1);
    range_pin = 1'b0; #1;
    check("R8 range 0 pin 0", out1_freq, 0);
  endtask

  task automatic t_discard();
    send(32'hFFFF, 16);
    expect_state("R4 unknown header", 6'h2A, 1, 2, 0);
    send(32'h7000 >> 1, 15);
    expect_state("R4 short word", 6'h2A, 1, 2, 0);
  endtask

  task automatic t_long_word_reserved_fs();
    int e0 = err_pulses;
    send(32'hF7153, 20);
    expect_state("R5 last 16 bits", 6'h15, 0, 3, 0);
    check("R9 one err pulse for fs 11", err_pulses - e0, 1);
  endtask

  task automatic t_power_down();
    send(32'h7000, 16);
    expect_state("R7 all enables clear", 0, 0, 0, 0);
    send(32'h7010, 16);
    expect_state("R7 resume while powered down", 1, 0, 0, 0);
  endtask

  task automatic t_reserved_rate();
    int e0 = err_pulses;
    send(32'h73FC, 16);
    expect_state("R9 rate 11 stored", 6'h3F, 3, 0, 0);
    check("R9 one err pulse for rate 11", err_pulses - e0, 1);
  endtask

  task automatic t_por();
    send(32'h7000, 16);
    send(32'h6C10, 16);
    @(negedge mclk) supply_ok = 1'b0;
    #1;
    expect_state("R10 supply drop", 6'h3F, 0, 0, 0);
    repeat (3) @(negedge mclk);
    supply_ok = 1'b1;
    send(32'h7000, 16);
    expect_state("R6 write ignored during reset window", 6'h3F, 0, 0, 0);
    repeat (900) @(negedge mclk);
    send(32'h7000, 16);
    expect_state("R6 write accepted after window", 0, 0, 0, 0);
  endtask

  initial begin
    repeat (5) @(negedge mclk);
    supply_ok = 1'b1;
    repeat (1100) @(negedge mclk);
    t_reset_defaults();
    t_mode_write();
    t_setup_write();
    t_discard();
    t_long_word_reserved_fs();
    t_power_down();
    t_reserved_rate();
    t_por();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge mclk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule